// File: doc/BRIEF.md
# Deskew Receiver Initialization Sequencer

This controller brings a source-synchronous serial receiver with per-channel dynamic phase alignment out of reset. It owns three reset outputs: one for the receive PLL, one for the phase aligner and one for the receive FIFO. It releases them in a fixed order, paced by two inputs. The first is the PLL lock, which includes clock-phase-alignment lock. The second is the aligner lock. When the FIFO reset has been released, the controller raises a ready flag and pulses a start strobe for the word-boundary alignment logic that follows it.

A restart request or a lock-loss indication returns the sequence to its first step at any time. Each wait for a lock indication has its own timeout. If a timeout expires, a sticky error flag is set and the sequence starts again. The lock signal that comes from the external PLL alone asserts earlier than the combined lock, and the controller never uses it to move forward. Once the receiver is running, a loss of aligner lock does not restart the sequence. The controller only records it in a flag.

Top module: `rxinit_seq`

## Requirements
- R1: While `rst_n` is low, `pll_rst` and `align_rst` are 1, and `fifo_rst`, `ready`, `word_align_start`, `align_drop_seen` and `timeout_err` are 0.
- R2: On entry to the sequence, `pll_rst` stays 1 for exactly PLL_RST_CYC clock cycles and then drops. `align_rst` stays 1 during this time.
- R3: Only `pll_lock_comb` moves the sequence on. `pll_lock_ext` has no effect on any output.
- R4: `align_rst` drops only after `pll_lock_comb` has been sampled high on STABLE_CYC consecutive cycles during the PLL wait. A single low sample restarts that count.
- R5: After `align_lock` is sampled high during the aligner wait, `fifo_rst` is 1 for exactly FIFO_RST_CYC cycles.
- R6: When `fifo_rst` drops, `ready` rises and stays 1 until a restart. All three resets are 0 while `ready` is 1.
- R7: `word_align_start` is a single-cycle pulse in the first cycle that `ready` is 1.
- R8: If `restart_req` or `lock_lost` is sampled high, then on the next cycle `pll_rst` and `align_rst` are 1 and `ready` is 0, and the sequence runs again from R2. `align_drop_seen` is cleared.
- R9: If `align_lock` falls while `ready` is 1, `align_drop_seen` is set and stays set, and `ready` stays 1.
- R10: If the sequence spends PLL_TMO cycles in the PLL wait without finishing, or ALIGN_TMO cycles in the aligner wait without lock, then `timeout_err` is set and the sequence restarts at R2. `timeout_err` is cleared only by `rst_n`.
- R11: If the lock condition completes on the same cycle that the timeout expires, the lock wins. The sequence advances and no error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_req | input | 1 | User request to rerun the whole sequence |
| lock_lost | input | 1 | Lock-loss indication; restarts the sequence |
| pll_lock_comb | input | 1 | Combined PLL and clock-phase-alignment lock |
| pll_lock_ext | input | 1 | Early lock from the external PLL only (ignored) |
| align_lock | input | 1 | Phase aligner lock |
| pll_rst | output | 1 | PLL reset |
| align_rst | output | 1 | Phase aligner reset |
| fifo_rst | output | 1 | Receive FIFO reset |
| ready | output | 1 | Data reception may proceed |
| word_align_start | output | 1 | One-cycle strobe to begin word alignment |
| align_drop_seen | output | 1 | Sticky: aligner lock fell while running |
| timeout_err | output | 1 | Sticky: a lock wait timed out |

## Verification
Two functions can fall in the same cycle. The first is the lock condition completing, either the last cycle of the stability window or the aligner lock arriving. The second is the expiry of the timeout for that same wait. The bench provokes this directly: it holds `pll_lock_comb` low for PLL_TMO minus STABLE_CYC cycles and then high for STABLE_CYC cycles, so the window closes on the very cycle the timeout expires. It then checks that `align_rst` is released and that `timeout_err` stays clear. Random stimulus also produces a restart request on the same cycle as a lock or an expiry, and a per-cycle reference model in the bench judges it: the restart wins, and no error is recorded.

// File: rtl/rxinit_pkg.sv
package rxinit_pkg;

  typedef enum logic [2:0] {
    ST_PLL_RST  = 3'd0,
    ST_PLL_WAIT = 3'd1,
    ST_ALN_WAIT = 3'd2,
    ST_FIFO_RST = 3'd3,
    ST_RUN      = 3'd4
  } seq_st_t;

  // True on the last cycle of a window of lim cycles counted from zero.
  function automatic logic at_last(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rxinit_tick_cnt.sv
module rxinit_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q + 1'b1;
  end

  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/rxinit_lock_filter.sv
module rxinit_lock_filter #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lock,
  output logic hit
);
  logic [W-1:0] run_q;

  assign hit = en && lock && rxinit_pkg::at_last(32'(run_q), 32'(N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!en || !lock)   run_q <= '0;
    else if (!hit)           run_q <= run_q + 1'b1;
  end

  p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lock) |=> (run_q == '0) && !hit);
endmodule

// File: rtl/rxinit_seq.sv
module rxinit_seq #(
  parameter int unsigned PLL_RST_CYC  = 4,
  parameter int unsigned STABLE_CYC   = 8,
  parameter int unsigned FIFO_RST_CYC = 2,
  parameter int unsigned PLL_TMO      = 64,
  parameter int unsigned ALIGN_TMO    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_req,
  input  logic lock_lost,
  input  logic pll_lock_comb,
  input  logic pll_lock_ext,
  input  logic align_lock,
  output logic pll_rst,
  output logic align_rst,
  output logic fifo_rst,
  output logic ready,
  output logic word_align_start,
  output logic align_drop_seen,
  output logic timeout_err
);
  import rxinit_pkg::*;

  localparam int unsigned MAXC = max4(PLL_RST_CYC, FIFO_RST_CYC, PLL_TMO, ALIGN_TMO);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_st_t       st_q, st_n;
  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          kick;
  logic          stable_hit;
  logic          pll_expired, aln_expired;
  logic          err_set, drop_set;
  logic          al_q;

  assign kick        = restart_req || lock_lost;
  assign pll_expired = at_last(32'(cnt), 32'(PLL_TMO));
  assign aln_expired = at_last(32'(cnt), 32'(ALIGN_TMO));

  rxinit_tick_cnt #(.W(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .q    (cnt)
  );

  rxinit_lock_filter #(.N(STABLE_CYC)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st_q == ST_PLL_WAIT),
    .lock (pll_lock_comb),
    .hit  (stable_hit)
  );

  always_comb begin
    st_n    = st_q;
    err_set = 1'b0;
    if (kick) begin
      st_n = ST_PLL_RST;
    end else begin
      unique case (st_q)
        ST_PLL_RST:
          if (at_last(32'(cnt), 32'(PLL_RST_CYC))) st_n = ST_PLL_WAIT;
        ST_PLL_WAIT:
          if (stable_hit) st_n = ST_ALN_WAIT;
          else if (pll_expired) begin st_n = ST_PLL_RST; err_set = 1'b1; end
        ST_ALN_WAIT:
          if (align_lock) st_n = ST_FIFO_RST;
          else if (aln_expired) begin st_n = ST_PLL_RST; err_set = 1'b1; end
        ST_FIFO_RST:
          if (at_last(32'(cnt), 32'(FIFO_RST_CYC))) st_n = ST_RUN;
        ST_RUN:  st_n = ST_RUN;
        default: st_n = ST_PLL_RST;
      endcase
    end
  end

  assign cnt_clr  = kick || (st_n != st_q);
  assign drop_set = (st_q == ST_RUN) && al_q && !align_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q             <= ST_PLL_RST;
      al_q             <= 1'b0;
      word_align_start <= 1'b0;
      align_drop_seen  <= 1'b0;
      timeout_err      <= 1'b0;
    end else begin
      st_q             <= st_n;
      al_q             <= align_lock;
      word_align_start <= (st_n == ST_RUN) && (st_q != ST_RUN);
      align_drop_seen  <= kick ? 1'b0 : (align_drop_seen || drop_set);
      timeout_err      <= timeout_err || err_set;
    end
  end

  assign pll_rst   = (st_q == ST_PLL_RST);
  assign align_rst = (st_q == ST_PLL_RST) || (st_q == ST_PLL_WAIT);
  assign fifo_rst  = (st_q == ST_FIFO_RST);
  assign ready     = (st_q == ST_RUN);

  // Assertions on the sequencing rules.
  p_pll_under_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> align_rst);
  p_ext_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (align_rst && !pll_rst && pll_lock_ext && !pll_lock_comb) |=> align_rst);
  p_align_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(align_rst) |-> $past(pll_lock_comb));
  p_fifo_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rst) |-> $past(align_lock));
  p_ready_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !pll_rst && !align_rst && !fifo_rst);
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_align_start |-> ready ##1 !word_align_start);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> pll_rst && align_rst && !ready && !align_drop_seen);
  p_drop_keeps_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !kick) |=> ready);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

// File: tb/sim_rxinit_seq.sv
module sim_rxinit_seq;
  localparam int unsigned PRC = 4;
  localparam int unsigned STC = 8;
  localparam int unsigned FRC = 2;
  localparam int unsigned PTO = 64;
  localparam int unsigned ATO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_req = 1'b0, lock_lost = 1'b0;
  logic pll_lock_comb = 1'b0, pll_lock_ext = 1'b0, align_lock = 1'b0;
  logic pll_rst, align_rst, fifo_rst, ready, word_align_start, align_drop_seen, timeout_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rxinit_seq #(.PLL_RST_CYC(PRC), .STABLE_CYC(STC), .FIFO_RST_CYC(FRC),
               .PLL_TMO(PTO), .ALIGN_TMO(ATO)) u0 (
    .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .lock_lost(lock_lost),
    .pll_lock_comb(pll_lock_comb), .pll_lock_ext(pll_lock_ext), .align_lock(align_lock),
    .pll_rst(pll_rst), .align_rst(align_rst), .fifo_rst(fifo_rst), .ready(ready),
    .word_align_start(word_align_start), .align_drop_seen(align_drop_seen),
    .timeout_err(timeout_err));

  // Reference model: stage 0 hold PLL reset, 1 PLL wait, 2 aligner wait, 3 FIFO reset, 4 running.
  int  m_stage = 0, m_hold = 0, m_wait = 0, m_streak = 0;
  bit  m_err = 0, m_drop = 0, m_start = 0, m_prev_al = 0;

  task automatic model_step(input bit r, input bit l, input bit pc, input bit al);
    m_start = 0;
    if (r || l) begin
      m_stage = 0; m_hold = 0; m_wait = 0; m_streak = 0; m_drop = 0;
    end else begin
      case (m_stage)
        0: begin
          m_hold++;
          if (m_hold == PRC) begin m_stage = 1; m_wait = 0; m_streak = 0; end
        end
        1: begin
          m_wait++;
          m_streak = pc ? m_streak + 1 : 0;
          if (m_streak == STC) begin m_stage = 2; m_wait = 0; end
          else if (m_wait == PTO) begin m_err = 1; m_stage = 0; m_hold = 0; end
        end
        2: begin
          m_wait++;
          if (al) begin m_stage = 3; m_hold = 0; end
          else if (m_wait == ATO) begin m_err = 1; m_stage = 0; m_hold = 0; end
        end
        3: begin
          m_hold++;
          if (m_hold == FRC) begin m_stage = 4; m_start = 1; end
        end
        default: if (m_prev_al && !al) m_drop = 1;
      endcase
    end
    m_prev_al = al;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2", pll_rst, m_stage == 0);
    check("R4", align_rst, m_stage <= 1);
    check("R5", fifo_rst, m_stage == 3);
    check("R6", ready, m_stage == 4);
    check("R7", word_align_start, m_start);
    check("R9", align_drop_seen, m_drop);
    check("R10", timeout_err, m_err);
  endtask

  // Inputs change at the falling edge; outputs are compared at the next falling edge.
  task automatic tick(input bit r, input bit l, input bit pc, input bit pe, input bit al);
    restart_req = r; lock_lost = l; pll_lock_comb = pc; pll_lock_ext = pe; align_lock = al;
    @(posedge clk);
    model_step(r, l, pc, al);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    check("R1", pll_rst, 1'b1);
    check("R1", align_rst, 1'b1);
    check("R1", fifo_rst, 1'b0);
    check("R1", ready, 1'b0);
    check("R1", word_align_start, 1'b0);
    check("R1", timeout_err, 1'b0);
    rst_n = 1'b1;

    // Bring-up with the external lock early and the combined lock late.
    for (int i = 0; i < PRC; i++) tick(0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 1, 0);
    check("R3", align_rst, 1'b1);
    for (int i = 0; i < 3; i++) tick(0, 0, 1, 1, 0);
    tick(0, 0, 0, 1, 0);
    check("R4", align_rst, 1'b1);
    for (int i = 0; i < STC; i++) tick(0, 0, 1, 1, 0);
    check("R4", align_rst, 1'b0);
    tick(0, 0, 1, 1, 1);
    check("R5", fifo_rst, 1'b1);
    for (int i = 0; i < FRC; i++) tick(0, 0, 1, 1, 1);
    check("R7", word_align_start, 1'b1);
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 1, 1);
    tick(0, 0, 1, 1, 0);
    check("R9", align_drop_seen, 1'b1);
    check("R9", ready, 1'b1);

    // Restart from the running state.
    tick(1, 0, 1, 1, 0);
    check("R8", pll_rst, 1'b1);
    check("R8", ready, 1'b0);
    check("R8", align_drop_seen, 1'b0);

    // Lock window closes on the very cycle the timeout expires.
    for (int i = 0; i < PRC; i++) tick(0, 0, 0, 0, 0);
    for (int i = 0; i < int'(PTO - STC); i++) tick(0, 0, 0, 1, 0);
    for (int i = 0; i < STC; i++) tick(0, 0, 1, 0, 0);
    check("R11", align_rst, 1'b0);
    check("R11", timeout_err, 1'b0);

    // Aligner lock never arrives.
    for (int i = 0; i < ATO; i++) tick(0, 0, 1, 0, 0);
    check("R10", timeout_err, 1'b1);
    check("R10", pll_rst, 1'b1);

    // Lock-loss restart.
    for (int i = 0; i < PRC + 2; i++) tick(0, 0, 1, 0, 0);
    tick(0, 1, 1, 0, 0);
    check("R8", pll_rst, 1'b1);

    // Constrained random phase.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit r, l, pc, pe, al;
      r  = ($urandom_range(0, 299) == 0);
      l  = ($urandom_range(0, 399) == 0);
      pc = ($urandom_range(0, 99) < 88);
      pe = $urandom_range(0, 1) == 1;
      al = ($urandom_range(0, 99) < 30) || (ready && $urandom_range(0, 99) < 90);
      tick(r, l, pc, pe, al);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule